// File: doc/BRIEF.md
# Sub-Scan Laplacian Sharpening Filter

This block sharpens a scanned image along the sub-scan (vertical) direction. Each cycle it may accept three 8-bit pixels taken at the same main-scan position from three consecutive lines: the line above, the current line and the line below. It computes the second difference `2*cur - (above + below)` as a signed value and scales it by a programmable gain. It adds the scaled value back to the current pixel and clamps the result to the pixel range. The three line streams come from line memories outside this block. A valid strobe qualifies the inputs, and a matching strobe qualifies the output.

The gain is an unsigned fixed-point number with 4 integer and 4 fraction bits. A gain of zero passes the current line through unchanged. Larger gains steepen edges between lines. The datapath has three register stages. The gain is captured together with its pixel triple, so the gain may change on every pixel.

Top module: `vsharp_top`

## Requirements
- R1: While `rstN` is low and after a clock edge, `outValid` is 0 and `pixOut` is 0.
- R2: `outValid` equals `inValid` delayed by exactly three clock cycles.
- R3: For a triple (A, N, B) with gain K, the result is `N + round(K * (2N - A - B) / 16)`. Rounding goes to the nearest integer, and an exact half rounds toward positive infinity (for example, a product of +8/16 gives +1 and -8/16 gives 0).
- R4: A result above 255 is output as 255.
- R5: A result below 0 is output as 0.
- R6: With K = 0, the output equals N of the same triple.
- R7: Each triple uses the K value that is present on `kGain` in its own input cycle. A K change in a later cycle has no effect on a triple already inside the pipeline.
- R8: `pixOut` keeps its last value in every cycle where `outValid` is 0.
- R9: For a flat column (A = N = B), the output equals N for any K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Qualifies the three input pixels and the gain |
| pixAbove | input | 8 | Pixel from the previous line (A) |
| pixCur | input | 8 | Pixel from the current line (N) |
| pixBelow | input | 8 | Pixel from the next line (B) |
| kGain | input | 8 | Unsigned gain, 4 integer and 4 fraction bits |
| outValid | output | 1 | Qualifies `pixOut` |
| pixOut | output | 8 | Sharpened and clamped pixel |

## Verification
The bench builds the block with its default parameters: 8-bit pixels and a gain with 4 integer and 4 fraction bits. With these defaults the full gain range up to 255/16 is reachable, so random triples with large contrast drive the result into both clamps, and the rounding ties at half a unit can be aimed at directly. Random valid gaps exercise the hold behaviour and the three-cycle alignment. A pattern that alternates the gain between 0 and its maximum on back-to-back pixels shows whether each pixel keeps its own gain.

// File: rtl/vsharp_pkg.sv
package vsharp_pkg;
  // Load strobes from the control module to the three datapath stages
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageLd_t;
endpackage

// File: rtl/vsharp_ctrl.sv
module vsharp_ctrl
  import vsharp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output stageLd_t ctl,
  output logic     outValid
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] vldPipe;
  logic [1:0]        sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldPipe  <= '0;
      sinceRst <= '0;
    end else begin
      vldPipe  <= {vldPipe[STAGES-2:0], inValid};
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  always_comb begin
    ctl.ld1 = inValid;
    ctl.ld2 = vldPipe[0];
    ctl.ld3 = vldPipe[1];
  end

  assign outValid = vldPipe[STAGES-1];

  // R2: output strobe lines up with the input strobe three cycles earlier
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));
endmodule

// File: rtl/vsharp_dp.sv
module vsharp_dp
  import vsharp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int K_INT  = 4,
  parameter int K_FRAC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  stageLd_t           ctl,
  input  logic [PIX_W-1:0]   pixAbove,
  input  logic [PIX_W-1:0]   pixCur,
  input  logic [PIX_W-1:0]   pixBelow,
  input  logic [K_INT+K_FRAC-1:0] kGain,
  output logic [PIX_W-1:0]   pixOut
);
  localparam int K_W    = K_INT + K_FRAC;
  localparam int DIFF_W = PIX_W + 3;
  localparam int PROD_W = DIFF_W + K_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [PROD_W-1:0] HALF    = PROD_W'(1) <<< (K_FRAC - 1);
  localparam logic signed [SUM_W-1:0]  PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  // Stage 1: second difference
  logic signed [DIFF_W-1:0] twoN, sumAB, diffNext;
  logic signed [DIFF_W-1:0] diff1;
  logic [PIX_W-1:0]         n1;
  logic [K_W-1:0]           k1;

  always_comb begin
    twoN     = {{(DIFF_W-PIX_W-1){1'b0}}, pixCur, 1'b0};
    sumAB    = DIFF_W'(pixAbove) + DIFF_W'(pixBelow);
    diffNext = twoN - sumAB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      diff1 <= '0;
      n1    <= '0;
      k1    <= '0;
    end else if (ctl.ld1) begin
      diff1 <= diffNext;
      n1    <= pixCur;
      k1    <= kGain;
    end
  end

  // Stage 2: gain multiply
  logic signed [PROD_W-1:0] diffExt, kExt, prodNext;
  logic signed [PROD_W-1:0] prod2;
  logic [PIX_W-1:0]         n2;

  always_comb begin
    diffExt  = PROD_W'(diff1);
    kExt     = PROD_W'($signed({1'b0, k1}));
    prodNext = diffExt * kExt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prod2 <= '0;
      n2    <= '0;
    end else if (ctl.ld2) begin
      prod2 <= prodNext;
      n2    <= n1;
    end
  end

  // Stage 3: round, add back, clamp
  logic signed [PROD_W-1:0] biased, rounded;
  logic signed [SUM_W-1:0]  total;
  logic [PIX_W-1:0]         clamped;

  always_comb begin
    biased  = prod2 + HALF;
    rounded = biased >>> K_FRAC;
    total   = SUM_W'(rounded) + SUM_W'($signed({1'b0, n2}));
    if (total < 0)            clamped = '0;
    else if (total > PIX_MAX) clamped = '1;
    else                      clamped = total[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        pixOut <= '0;
    else if (ctl.ld3) pixOut <= clamped;
  end

  // R6: zero gain passes the current pixel through
  assert_zero_gain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld3 && (prod2 == 0)) |=> (pixOut == $past(n2)));

  // R3: a non-negative correction never darkens the pixel
  assert_boost_dir_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld3 && (prod2 >= 0)) |=> (pixOut >= $past(n2)));

  // R3: a negative correction never brightens the pixel
  assert_cut_dir_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld3 && (prod2 < 0)) |=> (pixOut <= $past(n2)));

  // R8: output holds when no result arrives
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ld3 |=> $stable(pixOut));
endmodule

// File: rtl/vsharp_top.sv
module vsharp_top
  import vsharp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int K_INT  = 4,
  parameter int K_FRAC = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [PIX_W-1:0]        pixAbove,
  input  logic [PIX_W-1:0]        pixCur,
  input  logic [PIX_W-1:0]        pixBelow,
  input  logic [K_INT+K_FRAC-1:0] kGain,
  output logic                    outValid,
  output logic [PIX_W-1:0]        pixOut
);
  stageLd_t ctl;

  vsharp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  vsharp_dp #(
    .PIX_W  (PIX_W),
    .K_INT  (K_INT),
    .K_FRAC (K_FRAC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .pixAbove (pixAbove),
    .pixCur   (pixCur),
    .pixBelow (pixBelow),
    .kGain    (kGain),
    .pixOut   (pixOut)
  );
endmodule

// File: tb/tb_vsharp_top.sv
module tb_vsharp_top;
  localparam int KF = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] pixAbove, pixCur, pixBelow, kGain;
  logic       outValid;
  logic [7:0] pixOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  vsharp_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .pixAbove(pixAbove), .pixCur(pixCur), .pixBelow(pixBelow),
    .kGain(kGain), .outValid(outValid), .pixOut(pixOut)
  );

  // Model pipeline: slot 2 is the oldest entry, due at the next check
  logic       slotV [3];
  int         slotP [3];
  string      slotT [3];
  int         lastExp;

  function automatic int refPix(int a, int n, int b, int k);
    int d, p, r, v;
    d = 2 * n - (a + b);
    p = d * k;
    r = (p + (1 << (KF - 1))) >>> KF;
    v = n + r;
    if (v < 0)   v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic clearModel();
    for (int i = 0; i < 3; i++) begin
      slotV[i] = 1'b0; slotP[i] = 0; slotT[i] = "R8";
    end
    lastExp = 0;
  endtask

  // One cycle: check the due result at the negedge, then drive new inputs
  task automatic step(input int a, input int n, input int b, input int k,
                      input logic v, input string tag);
    @(negedge clk);
    nChecks++;
    if (outValid !== slotV[2]) begin
      nFails++;
      $display("FAIL R2: outValid=%0d expected %0d", outValid, slotV[2]);
    end
    nChecks++;
    if (pixOut !== slotP[2][7:0]) begin
      nFails++;
      $display("FAIL %s: pixOut=%0d expected %0d", slotT[2], pixOut, slotP[2]);
    end
    slotV[2] = slotV[1]; slotP[2] = slotP[1]; slotT[2] = slotT[1];
    slotV[1] = slotV[0]; slotP[1] = slotP[0]; slotT[1] = slotT[0];
    if (v) lastExp = refPix(a, n, b, k);
    slotV[0] = v; slotP[0] = lastExp; slotT[0] = v ? tag : "R8";
    inValid  = v;
    pixAbove = a[7:0]; pixCur = n[7:0]; pixBelow = b[7:0]; kGain = k[7:0];
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #(4 * 190000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    void'($urandom(32'd1234));
    clearModel();
    rstN = 1'b0; inValid = 1'b1;
    pixAbove = 8'd0; pixCur = 8'd200; pixBelow = 8'd0; kGain = 8'd16;

    // R1: reset state, even with valid inputs driven
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      nChecks++;
      if (outValid !== 1'b0 || pixOut !== 8'd0) begin
        nFails++;
        $display("FAIL R1: outValid=%0d pixOut=%0d expected 0/0", outValid, pixOut);
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R6: zero gain, assorted columns
    step(10, 77, 250, 0, 1'b1, "R6");
    step(255, 0, 255, 0, 1'b1, "R6");
    step(0, 255, 0, 0, 1'b1, "R6");
    // R9: flat columns with any gain
    step(90, 90, 90, 255, 1'b1, "R9");
    step(0, 0, 0, 200, 1'b1, "R9");
    step(255, 255, 255, 17, 1'b1, "R9");
    // R4: high clamp
    step(0, 200, 0, 16, 1'b1, "R4");
    step(0, 255, 0, 255, 1'b1, "R4");
    // R5: low clamp
    step(255, 50, 255, 255, 1'b1, "R5");
    step(255, 1, 255, 16, 1'b1, "R5");
    // R3: rounding ties (+8/16 -> +1, -8/16 -> 0) and plain cases
    step(99, 100, 100, 8, 1'b1, "R3");
    step(101, 100, 100, 8, 1'b1, "R3");
    step(100, 100, 97, 24, 1'b1, "R3");
    step(100, 110, 120, 40, 1'b1, "R3");
    // R8: gaps hold the last output
    step(1, 2, 3, 4, 1'b0, "R8");
    step(0, 255, 0, 255, 1'b0, "R8");
    step(40, 60, 20, 32, 1'b1, "R3");
    step(0, 0, 0, 0, 1'b0, "R8");
    step(0, 0, 0, 0, 1'b0, "R8");
    step(0, 0, 0, 0, 1'b0, "R8");
    step(0, 0, 0, 0, 1'b0, "R8");
    // R7: gain alternating every pixel
    for (int i = 0; i < 16; i++)
      step(30, 120, 60, (i % 2 == 0) ? 0 : 255, 1'b1, "R7");

    // Random traffic, mixed gain ranges
    for (int i = 0; i < 3000; i++) begin
      int a, n, b, k;
      logic v;
      a = int'($urandom_range(255));
      n = int'($urandom_range(255));
      b = int'($urandom_range(255));
      k = (i % 3 == 0) ? int'($urandom_range(31)) : int'($urandom_range(255));
      v = ($urandom_range(9) < 8);
      step(a, n, b, k, v, "R3");
    end

    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1'b0, "R8");
    summary();
    $finish;
  end
endmodule